// File: doc/BRIEF.md
# Four-Channel Timing Mode Router

This block sits between the pattern sequencer and four timing channels. Every rising edge of the main clock it samples a set of control inputs and passes them to the channels: a shared period-start strobe, a mask vector with one bit per edge, one pattern-data vector per channel, and one global input-delay vector. For each channel it drives a period-start strobe, a waveform-memory address, an input-delay value and a set of edge fail-mask flags.

A single mode-enable input decides what the mask and pattern-data inputs mean. In normal mode, the shared strobe starts every channel's period. Each channel's pattern-data vector selects its waveform-memory location. The global delay feeds all channels, and mask bit e suppresses fail checking on edge e of every channel. In clock-generator mode, mask bit n becomes the private period start of channel n. Each pattern-data vector becomes that channel's input delay, memory addresses are pinned to location zero, and fail masking is switched off. All outputs are registered. The asynchronous reset input is synchronised inside the block before it reaches the output registers.

Top module: `tmr_top`

## Requirements
- R1: While rst_n is low, every output is 0. Asserting rst_n clears the outputs at once, without waiting for a clock edge.
- R2: Normal mode (clkgen_en = 0): every bit of period_start_o equals period_start_i.
- R3: Clock-generator mode (clkgen_en = 1): period_start_o bit n equals mask_i bit n.
- R4: Normal mode: channel n's waveform address, wave_addr_o[n*PAT_W +: PAT_W], equals channel n's pattern data, pat_data_i[n*PAT_W +: PAT_W].
- R5: Clock-generator mode: every channel's waveform address is 0.
- R6: Normal mode: every channel's input delay, in_delay_o[n*PAT_W +: PAT_W], equals in_delay_i.
- R7: Clock-generator mode: channel n's input delay equals pat_data_i[n*PAT_W +: PAT_W].
- R8: Normal mode: channel n's fail-mask field, fail_mask_o[n*NUM_CH +: NUM_CH], equals mask_i. Bit e of the field masks edge e.
- R9: Clock-generator mode: every fail-mask bit is 0.
- R10: Every output shows the inputs, including clkgen_en, that were sampled at the previous rising clock edge. A mode change therefore takes effect on the next edge, together with the data sampled at that edge.
- R11: After rst_n is released, the outputs stay 0 through the first two rising clock edges. The third rising edge loads the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkgen_en | input | 1 | Mode select: 0 normal, 1 clock-generator |
| period_start_i | input | 1 | Shared period-start strobe |
| mask_i | input | NUM_CH | Per-edge mask / per-channel start vector |
| pat_data_i | input | NUM_CH*PAT_W | Per-channel pattern data, channel n at bits n*PAT_W |
| in_delay_i | input | PAT_W | Global input delay |
| period_start_o | output | NUM_CH | Per-channel period-start strobe |
| wave_addr_o | output | NUM_CH*PAT_W | Per-channel waveform-memory address |
| in_delay_o | output | NUM_CH*PAT_W | Per-channel input delay |
| fail_mask_o | output | NUM_CH*NUM_CH | Per-channel edge fail masks, channel n at bits n*NUM_CH |

## Verification
The embedded properties check, on every cycle out of reset, that each channel's outputs match the mode-dependent mapping of the inputs sampled one edge earlier. They also check that the reset synchroniser's stages fill in order. Some behaviour can only be shown by the bench's scenarios. These are the immediate clearing of outputs when reset is asserted mid-run, the two zero cycles after reset release, and mode toggling on every cycle with the data aligned to the new mode. The bench also drives extreme data values, all-zero and all-one, in both modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_CLKGEN = 1'b1
  } mode_e;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_no = stage_q[STAGES-1];

  // R11: the last stage can only be high once the first stage is high
  p_stage_order_r11: assert property (@(posedge clk_i) disable iff (!arst_ni)
    stage_q[STAGES-1] |-> stage_q[0]);

endmodule

// File: rtl/tmr_chan_route.sv
module tmr_chan_route
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PAT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              shared_start_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              own_mask_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic [PAT_W-1:0]  gdelay_i,
  output logic              start_o,
  output logic [PAT_W-1:0]  addr_o,
  output logic [PAT_W-1:0]  delay_o,
  output logic [NUM_CH-1:0] fmask_o
);

  mode_e             mode;
  logic              start_d;
  logic [PAT_W-1:0]  addr_d;
  logic [PAT_W-1:0]  delay_d;
  logic [NUM_CH-1:0] fmask_d;

  assign mode = mode_e'(mode_i);

  always_comb begin
    if (mode == MODE_CLKGEN) begin
      start_d = own_mask_i;
      addr_d  = '0;
      delay_d = pat_i;
      fmask_d = '0;
    end else begin
      start_d = shared_start_i;
      addr_d  = pat_i;
      delay_d = gdelay_i;
      fmask_d = mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      addr_o  <= '0;
      delay_o <= '0;
      fmask_o <= '0;
    end else begin
      start_o <= start_d;
      addr_o  <= addr_d;
      delay_o <= delay_d;
      fmask_o <= fmask_d;
    end
  end

  p_start_norm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> start_o == $past(shared_start_i));
  p_start_clkgen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> start_o == $past(own_mask_i));
  p_addr_norm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> addr_o == $past(pat_i));
  p_addr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> addr_o == '0);
  p_delay_norm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> delay_o == $past(gdelay_i));
  p_delay_clkgen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> delay_o == $past(pat_i));
  p_fmask_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> fmask_o == '0);

endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int NUM_CH      = 4,
  parameter int PAT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clkgen_en,
  input  logic                      period_start_i,
  input  logic [NUM_CH-1:0]         mask_i,
  input  logic [NUM_CH*PAT_W-1:0]   pat_data_i,
  input  logic [PAT_W-1:0]          in_delay_i,
  output logic [NUM_CH-1:0]         period_start_o,
  output logic [NUM_CH*PAT_W-1:0]   wave_addr_o,
  output logic [NUM_CH*PAT_W-1:0]   in_delay_o,
  output logic [NUM_CH*NUM_CH-1:0]  fail_mask_o
);

  localparam int FM_W = NUM_CH * NUM_CH;

  logic rst_sync_n;

  tmr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i   (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_sync_n)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    tmr_chan_route #(
      .NUM_CH (NUM_CH),
      .PAT_W  (PAT_W)
    ) u_chan (
      .clk_i          (clk),
      .rst_ni         (rst_sync_n),
      .mode_i         (clkgen_en),
      .shared_start_i (period_start_i),
      .mask_i         (mask_i),
      .own_mask_i     (mask_i[n]),
      .pat_i          (pat_data_i[n*PAT_W +: PAT_W]),
      .gdelay_i       (in_delay_i),
      .start_o        (period_start_o[n]),
      .addr_o         (wave_addr_o[n*PAT_W +: PAT_W]),
      .delay_o        (in_delay_o[n*PAT_W +: PAT_W]),
      .fmask_o        (fail_mask_o[n*NUM_CH +: NUM_CH])
    );
  end

  // R8: in normal mode every channel carries the same edge mask, one edge later
  p_fmask_bcast_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clkgen_en |=> fail_mask_o == FM_W'({NUM_CH{$past(mask_i)}}));

endmodule

// File: tb/test_tmr_top.sv
module test_tmr_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int PAT_W  = 6;
  localparam int FLAT   = NUM_CH * PAT_W;
  localparam int FM_W   = NUM_CH * NUM_CH;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              clkgen_en;
  logic              period_start_i;
  logic [NUM_CH-1:0] mask_i;
  logic [FLAT-1:0]   pat_data_i;
  logic [PAT_W-1:0]  in_delay_i;
  logic [NUM_CH-1:0] period_start_o;
  logic [FLAT-1:0]   wave_addr_o;
  logic [FLAT-1:0]   in_delay_o;
  logic [FM_W-1:0]   fail_mask_o;

  tmr_top #(.NUM_CH(NUM_CH), .PAT_W(PAT_W)) i_tmr_top (
    .clk(clk), .rst_n(rst_n), .clkgen_en(clkgen_en),
    .period_start_i(period_start_i), .mask_i(mask_i),
    .pat_data_i(pat_data_i), .in_delay_i(in_delay_i),
    .period_start_o(period_start_o), .wave_addr_o(wave_addr_o),
    .in_delay_o(in_delay_o), .fail_mask_o(fail_mask_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int                stamp;
    logic              mode;
    logic              toggled;
    logic [NUM_CH-1:0] st;
    logic [FLAT-1:0]   addr;
    logic [FLAT-1:0]   dly;
    logic [FM_W-1:0]   fm;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  logic  last_mode = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic item_t model(logic m, logic s, logic [NUM_CH-1:0] mk,
                                  logic [FLAT-1:0] p, logic [PAT_W-1:0] g);
    item_t it;
    it.stamp = 0;
    it.mode = m;
    it.toggled = 1'b0;
    if (m) begin
      it.st = mk; it.addr = '0; it.dly = p; it.fm = '0;
    end else begin
      it.st = {NUM_CH{s}}; it.addr = p;
      it.dly = {NUM_CH{g}}; it.fm = {NUM_CH{mk}};
    end
    return it;
  endfunction

  task automatic cmp_item(item_t it, string extra);
    string sfx;
    sfx = it.toggled ? {" R10", extra} : extra;
    chk({it.mode ? "R3" : "R2", sfx, " start"}, 64'(period_start_o), 64'(it.st));
    chk({it.mode ? "R5" : "R4", sfx, " addr"},  64'(wave_addr_o),    64'(it.addr));
    chk({it.mode ? "R7" : "R6", sfx, " delay"}, 64'(in_delay_o),     64'(it.dly));
    chk({it.mode ? "R9" : "R8", sfx, " fmask"}, 64'(fail_mask_o),    64'(it.fm));
  endtask

  // monitor: pop items whose capture edge has already passed
  always @(negedge clk) begin
    item_t it;
    if (sbq.size() > 0 && sbq[0].stamp < cyc) begin
      it = sbq.pop_front();
      cmp_item(it, "");
    end
  end

  task automatic drive(logic m, logic s, logic [NUM_CH-1:0] mk,
                       logic [FLAT-1:0] p, logic [PAT_W-1:0] g);
    item_t it;
    @(negedge clk);
    clkgen_en = m; period_start_i = s; mask_i = mk;
    pat_data_i = p; in_delay_i = g;
    it = model(m, s, mk, p, g);
    it.stamp = cyc;
    it.toggled = (m != last_mode);
    last_mode = m;
    sbq.push_back(it);
  endtask

  task automatic check_zero(string tag);
    chk({tag, " start"}, 64'(period_start_o), 64'd0);
    chk({tag, " addr"},  64'(wave_addr_o),    64'd0);
    chk({tag, " delay"}, 64'(in_delay_o),     64'd0);
    chk({tag, " fmask"}, 64'(fail_mask_o),    64'd0);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [FLAT-1:0] rnd_pat();
    logic [FLAT-1:0] v;
    v = FLAT'({$urandom(), $urandom()});
    return v;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    item_t ref_it;
    rst_n = 1'b0;
    clkgen_en = 1'b0; period_start_i = 1'b1; mask_i = 4'hF;
    pat_data_i = 24'hA5C3F1; in_delay_i = 6'h2B;
    repeat (3) @(negedge clk);
    check_zero("R1 in reset");

    // release and watch the two synchroniser cycles
    rst_n = 1'b1;
    @(negedge clk); check_zero("R11 edge1");
    @(negedge clk); check_zero("R11 edge2");
    @(negedge clk);
    ref_it = model(1'b0, 1'b1, 4'hF, 24'hA5C3F1, 6'h2B);
    cmp_item(ref_it, " R11 edge3");

    // normal mode, varied data
    for (int i = 0; i < 20; i++)
      drive(1'b0, 1'($urandom()), 4'($urandom()), rnd_pat(), 6'($urandom()));
    // clock-generator mode, varied data
    for (int i = 0; i < 20; i++)
      drive(1'b1, 1'($urandom()), 4'($urandom()), rnd_pat(), 6'($urandom()));
    // toggle mode every cycle
    for (int i = 0; i < 16; i++)
      drive(1'(i % 2), 1'($urandom()), 4'($urandom()), rnd_pat(), 6'($urandom()));
    // extremes in both modes
    drive(1'b0, 1'b1, 4'hF, '1, '1);
    drive(1'b0, 1'b0, 4'h0, '0, '0);
    drive(1'b1, 1'b1, 4'hF, '1, '1);
    drive(1'b1, 1'b0, 4'h0, '0, '0);
    drive(1'b1, 1'b0, 4'b1010, 24'h3F003F, 6'h15);
    drive(1'b0, 1'b1, 4'b0101, 24'h00FC0F, 6'h2A);
    drain();

    // asynchronous reset in mid-cycle with nonzero outputs
    drive(1'b0, 1'b1, 4'hF, '1, '1);
    drain();
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1 check_zero("R1 async");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); check_zero("R11 again edge1");
    @(negedge clk); check_zero("R11 again edge2");
    last_mode = 1'b0;
    for (int i = 0; i < 8; i++)
      drive(1'($urandom()), 1'($urandom()), 4'($urandom()), rnd_pat(), 6'($urandom()));
    drain();

    summary();
    $finish;
  end

endmodule